// File: doc/BRIEF.md
# Serial Register Control Port

This block is the control-side slave of a converter device. An external controller drives an active-low latch, a serial clock and a serial data line. Through them it writes and reads a small bank of 8-bit configuration registers. The rest of the chip uses these registers to set up its clocking, its power-down state and its converter options. Each transaction is one 24-bit word, sent most significant bit first. The top byte holds a fixed 7-bit chip identifier followed by a direction flag. The middle byte selects a register. The bottom byte carries the write data, or it is the slot in which the block returns the register contents.

The serial side runs from the serial clock and the latch alone, so it may be fully asynchronous to the core clock. A completed write is captured when the latch rises. It is then handed to the core clock domain with a toggle and a two-flop synchronizer, and the register bank is updated there. When the core clock first ticks after reset is released, the block samples the serial pins. If all three are low, the device enters a self-configured mode and the serial port is ignored from then on. In that mode the internal master clock enable is set, and the level strapped on the data-out pad chooses whether the converter bit and frame clocks are generated locally.

Top module: `spi_ctrl_port`

## Requirements
- R1: After reset in serial mode, every register reads 0x00 except register 1, which reads 0x24. `standalone` is 0 and `mclk_en` is 0.
- R2: While `cs_n` is low, `mosi` is sampled on each rising edge of `sck`. Bit 23 comes first. Bits 23:17 must equal 0x04 and bit 16 is the direction flag (0 = write, 1 = read). Bits 15:8 are the register number and bits 7:0 the data. A valid write shows on `cfg_flat` (register n at bits 8n+7:8n) within 6 core clocks of `cs_n` rising.
- R3: A frame with any bit count other than 24 (for example 23 or 25) changes no register.
- R4: A frame whose bits 23:17 differ from 0x04 changes no register, and `sdo_en` stays low through it.
- R5: In a valid read, `sdo_en` is high and `sdo` carries the addressed register MSB first, updating on falling `sck` edges, while `sck` is high during bits 16 to 23. At every other time `sdo_en` is low, and it goes low at once when `cs_n` is high.
- R6: Writes to register numbers at or above NUM_REGS (8) change nothing. Reads from them return 0x00.
- R7: If `cs_n`, `sck` and `mosi` are all low at the first core clock after reset release, `standalone` becomes 1 and register 0 holds 0x80 (`mclk_en` = 1). All other registers keep their reset values, and later frames neither write nor drive `sdo_en`.
- R8: In standalone mode, register 3 bit 6 (`adc_clk_master`) takes the level of `sdo_strap` sampled at that same clock: 1 selects master, 0 selects slave.
- R9: The field outputs decode as follows: `mclk_en` = reg0[7], `pll_pd` = reg0[0], `dac_pd` = reg2[0], `adc_pd` = reg3[0], `adc_clk_master` = reg3[6]. A write touches only its own register, so setting a power-down bit leaves all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame latch, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| sdo_strap | input | 1 | Level on the data-out pad, sampled for the standalone clock role |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Data-out pad drive enable; pad is high-impedance when low |
| standalone | output | 1 | Self-configured mode latched at reset |
| mclk_en | output | 1 | Internal master clock enable |
| pll_pd | output | 1 | PLL power-down |
| dac_pd | output | 1 | DAC section power-down |
| adc_pd | output | 1 | ADC section power-down |
| adc_clk_master | output | 1 | ADC bit/frame clocks generated locally |
| cfg_flat | output | NUM_REGS*8 | All register contents, register n at bits 8n+7:8n |

## Verification
A bit counter that slips would move every later field by one position. A wrong count also shows within a single frame: `sdo_en` rises at the wrong bit, or the readback comes out shifted. A lost or duplicated crossing toggle would leave `cfg_flat` stale, or rewrite it, a few core clocks after the latch rises. The bench therefore compares `cfg_flat` after every frame, and also after every rejected frame. A wrong mode latch shows at once on `standalone` and `mclk_en`, because the port then either answers when it should be silent or stays silent when it should answer.

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port #(
  parameter int NUM_REGS = 8,
  parameter logic [6:0] CHIP_ADDR = 7'h04
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sck,
  input  logic                  mosi,
  input  logic                  sdo_strap,
  output logic                  sdo,
  output logic                  sdo_en,
  output logic                  standalone,
  output logic                  mclk_en,
  output logic                  pll_pd,
  output logic                  dac_pd,
  output logic                  adc_pd,
  output logic                  adc_clk_master,
  output logic [NUM_REGS*8-1:0] cfg_flat
);
  localparam int FRAME_BITS = 24;
  localparam int CW = $clog2(FRAME_BITS + 2);
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CNT_OVER = CW'(FRAME_BITS + 1);
  localparam logic [CW-1:0] CNT_DATA = CW'(16);

  function automatic logic [7:0] reg_default(int idx);
    return (idx == 1) ? 8'h24 : 8'h00;
  endfunction

  logic [CW-1:0]   bit_cnt;
  logic [23:0]     shreg;
  logic            spi_clr;
  logic            req_tgl;
  logic [7:0]      hold_addr, hold_data;
  logic [2:0]      req_sync;
  logic            init_done;
  logic            wr_stb;
  logic            pins_low;
  logic [7:0]      regs [NUM_REGS];
  logic [7:0]      rd_byte;
  logic [7:0]      out_sr;
  logic            frame_ok, rd_hit;

  assign spi_clr = cs_n | ~rst_n;

  always_ff @(posedge sck or posedge spi_clr)
    if (spi_clr) bit_cnt <= '0;
    else if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;

  always_ff @(posedge sck or negedge rst_n)
    if (!rst_n) shreg <= '0;
    else shreg <= {shreg[22:0], mosi};

  assign frame_ok = (bit_cnt == CNT_FULL) && (shreg[23:17] == CHIP_ADDR) && !shreg[16];

  always_ff @(posedge cs_n or negedge rst_n)
    if (!rst_n) begin
      req_tgl   <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else if (frame_ok) begin
      req_tgl   <= ~req_tgl;
      hold_addr <= shreg[15:8];
      hold_data <= shreg[7:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req_sync <= '0;
    else req_sync <= {req_sync[1:0], req_tgl};

  assign pins_low = !cs_n && !sck && !mosi;
  assign wr_stb   = (req_sync[2] ^ req_sync[1]) && init_done && !standalone;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      init_done  <= 1'b0;
      standalone <= 1'b0;
    end else if (!init_done) begin
      init_done  <= 1'b1;
      standalone <= pins_low;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_default(i);
    end else if (!init_done) begin
      if (pins_low) begin
        regs[0][7] <= 1'b1;
        regs[3][6] <= sdo_strap;
      end
    end else if (wr_stb) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (hold_addr == 8'(i)) regs[i] <= hold_data;
    end

  assign rd_byte = (int'(shreg[7:0]) < NUM_REGS) ? regs[shreg[AW-1:0]] : 8'h00;
  assign rd_hit  = (bit_cnt == CNT_DATA) && (shreg[15:9] == CHIP_ADDR) && shreg[8] && !standalone;

  always_ff @(negedge sck or posedge spi_clr)
    if (spi_clr) begin
      sdo_en <= 1'b0;
      out_sr <= '0;
    end else if (rd_hit) begin
      sdo_en <= 1'b1;
      out_sr <= rd_byte;
    end else if (sdo_en) begin
      if (bit_cnt >= CNT_FULL) sdo_en <= 1'b0;
      out_sr <= {out_sr[6:0], 1'b0};
    end

  assign sdo = sdo_en & out_sr[7];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign cfg_flat[g*8 +: 8] = regs[g];
  end

  assign mclk_en        = regs[0][7];
  assign pll_pd         = regs[0][0];
  assign dac_pd         = regs[2][0];
  assign adc_pd         = regs[3][0];
  assign adc_clk_master = regs[3][6];
endmodule

// File: rtl/spi_ctrl_port_chk.sv
module spi_ctrl_port_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  sdo_en,
  input logic                  standalone,
  input logic                  mclk_en,
  input logic                  wr_stb,
  input logic                  init_done,
  input logic [NUM_REGS*8-1:0] cfg_flat
);
  AST_SDO_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdo_en); // R5

  AST_STANDALONE_CLOCK_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && standalone) |-> mclk_en); // R7

  AST_STANDALONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    standalone |-> (!sdo_en && !wr_stb)); // R7

  AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> $stable(standalone)); // R7

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !wr_stb) |=> $stable(cfg_flat)); // R9
endmodule

bind spi_ctrl_port spi_ctrl_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_en(sdo_en),
  .standalone(standalone), .mclk_en(mclk_en), .wr_stb(wr_stb),
  .init_done(init_done), .cfg_flat(cfg_flat)
);

// File: tb/spi_ctrl_port_test.sv
module spi_ctrl_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, mosi, sdo_strap;
  logic sdo, sdo_en, standalone, mclk_en, pll_pd, dac_pd, adc_pd, adc_clk_master;
  logic [NREG*8-1:0] cfg_flat;

  int total = 0;
  int bad = 0;
  logic [7:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ctrl_port #(.NUM_REGS(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .sdo_strap(sdo_strap), .sdo(sdo), .sdo_en(sdo_en), .standalone(standalone),
    .mclk_en(mclk_en), .pll_pd(pll_pd), .dac_pd(dac_pd), .adc_pd(adc_pd),
    .adc_clk_master(adc_clk_master), .cfg_flat(cfg_flat)
  );

  function automatic logic [7:0] def_val(int i);
    return (i == 1) ? 8'h24 : 8'h00;
  endfunction

  function automatic logic [NREG*8-1:0] packed_model();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    return (int'(a) < NREG) ? model[a[2:0]] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) model[i] = def_val(i);
  endtask

  task automatic do_reset(input bit stand, input bit strap);
    rst_n = 1'b0; sck = 1'b0; mosi = 1'b0;
    cs_n = stand ? 1'b0 : 1'b1;
    sdo_strap = strap;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1; sdo_strap = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] word, input int nbits, output logic [7:0] rdat,
                      output bit en_early, output bit en_data_all, output bit en_any);
    rdat = 8'h00; en_early = 1'b0; en_data_all = 1'b1; en_any = 1'b0;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      mosi = (k < 24) ? word[23-k] : 1'b0;
      repeat (3) @(negedge clk);
      sck = 1'b1;
      @(negedge clk);
      if (sdo_en) en_any = 1'b1;
      if (k < 16 && sdo_en) en_early = 1'b1;
      if (k >= 16 && k < 24) begin
        if (!sdo_en) en_data_all = 1'b0;
        rdat[23-k] = sdo;
      end
      repeat (2) @(negedge clk);
      sck = 1'b0;
    end
    repeat (3) @(negedge clk);
    if (sdo_en) en_any = 1'b1;
    cs_n = 1'b1;
    mosi = 1'b0;
    @(negedge clk);
    chk(!sdo_en, "R5 sdo_en after latch high", 64'(sdo_en), 64'd0);
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] chip, input logic [7:0] a, input logic [7:0] d, input int nbits);
    logic [7:0] r; bit e0, e1, e2;
    xfer({chip, 1'b0, a, d}, nbits, r, e0, e1, e2);
    if (chip == 7'h04 && nbits == 24 && int'(a) < NREG) model[a[2:0]] = d;
    chk(cfg_flat == packed_model(), "R2/R3/R4/R6 cfg after write frame", 64'(cfg_flat), 64'(packed_model()));
  endtask

  task automatic rd(input logic [6:0] chip, input logic [7:0] a);
    logic [7:0] r; bit e0, e1, e2;
    xfer({chip, 1'b1, a, 8'h00}, 24, r, e0, e1, e2);
    if (chip == 7'h04) begin
      chk(r == exp_read(a), "R5/R6 readback data", 64'(r), 64'(exp_read(a)));
      chk(!e0 && e1, "R5 sdo_en window", 64'({e0, e1}), 64'b01);
    end else begin
      chk(!e2, "R4 no drive on foreign chip address", 64'(e2), 64'd0);
    end
    chk(cfg_flat == packed_model(), "R4/R5 read leaves cfg", 64'(cfg_flat), 64'(packed_model()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run hung actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r; bit e0, e1, e2;
    void'($urandom(32'd5150));

    do_reset(1'b0, 1'b0);
    chk(standalone == 1'b0, "R1 serial mode after reset", 64'(standalone), 64'd0);
    chk(mclk_en == 1'b0, "R1 mclk_en reset", 64'(mclk_en), 64'd0);
    chk(cfg_flat == packed_model(), "R1 reset defaults", 64'(cfg_flat), 64'(packed_model()));
    for (int a = 0; a < NREG; a++) rd(7'h04, 8'(a));

    wr(7'h04, 8'h00, 8'h81, 24);
    chk(mclk_en && pll_pd, "R9 reg0 fields", 64'({mclk_en, pll_pd}), 64'b11);
    chk(sdo == 1'b0 && sdo_en == 1'b0, "R5 idle sdo", 64'({sdo, sdo_en}), 64'd0);

    wr(7'h04, 8'h02, 8'h5A, 23);
    wr(7'h04, 8'h02, 8'h5A, 25);
    wr(7'h05, 8'h02, 8'h5A, 24);
    rd(7'h05, 8'h01);
    rd(7'h02, 8'h01);
    wr(7'h04, 8'h20, 8'hEE, 24);
    rd(7'h04, 8'h20);
    rd(7'h04, 8'hFF);

    wr(7'h04, 8'h02, 8'h01, 24);
    chk(dac_pd == 1'b1, "R9 dac power-down", 64'(dac_pd), 64'd1);
    wr(7'h04, 8'h03, 8'h41, 24);
    chk(adc_pd && adc_clk_master && dac_pd && mclk_en, "R9 adc fields, others kept",
        64'({adc_pd, adc_clk_master, dac_pd, mclk_en}), 64'hF);

    for (int n = 0; n < 120; n++) begin
      int kind;
      logic [7:0] a, d;
      kind = int'($urandom_range(0, 9));
      a = 8'($urandom_range(0, 9));
      d = 8'($urandom);
      if (kind < 5) wr(7'h04, a, d, 24);
      else if (kind < 8) rd(7'h04, a);
      else if (kind == 8) wr(7'h04, a, d, ($urandom_range(0, 1) == 0) ? 22 : 26);
      else wr(7'($urandom_range(5, 127)), a, d, 24);
    end
    for (int a = 0; a < NREG; a++) rd(7'h04, 8'(a));

    do_reset(1'b1, 1'b1);
    model[0] = 8'h80;
    model[3] = 8'h40;
    chk(standalone == 1'b1, "R7 standalone latched", 64'(standalone), 64'd1);
    chk(mclk_en == 1'b1, "R7 mclk_en forced", 64'(mclk_en), 64'd1);
    chk(adc_clk_master == 1'b1, "R8 strap high selects master", 64'(adc_clk_master), 64'd1);
    chk(cfg_flat == packed_model(), "R7 other defaults kept", 64'(cfg_flat), 64'(packed_model()));
    xfer({7'h04, 1'b0, 8'h01, 8'h99}, 24, r, e0, e1, e2);
    chk(cfg_flat == packed_model(), "R7 write ignored in standalone", 64'(cfg_flat), 64'(packed_model()));
    xfer({7'h04, 1'b1, 8'h01, 8'h00}, 24, r, e0, e1, e2);
    chk(!e2, "R7 no readback drive in standalone", 64'(e2), 64'd0);

    do_reset(1'b1, 1'b0);
    model[0] = 8'h80;
    chk(adc_clk_master == 1'b0, "R8 strap low selects slave", 64'(adc_clk_master), 64'd0);
    chk(cfg_flat == packed_model(), "R8 standalone cfg", 64'(cfg_flat), 64'(packed_model()));

    do_reset(1'b0, 1'b1);
    chk(standalone == 1'b0 && mclk_en == 1'b0, "R1 serial mode again", 64'({standalone, mclk_en}), 64'd0);
    chk(cfg_flat == packed_model(), "R1 defaults after second reset", 64'(cfg_flat), 64'(packed_model()));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule